// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Target

This block is the bus-side front end of a boot memory that sits on a 4-bit multiplexed firmware bus. It watches an active-low frame strobe and a shared 4-bit bus. It decodes each frame into its phases: the opening code, the target select, a 28-bit address, the size field, the turnaround, the handshake and the data. On reads it drives the bus back to the host.

Accesses whose address has bit 22 set are handed to an internal request port, which stands in for the memory array and its command logic. That port carries the direction, the address and the write byte. It answers with a ready pulse, an error flag and the read byte. While the port is busy, the target holds the host off with wait codes.

Accesses with address bit 22 clear are answered by a small register window inside the block. This window returns identification bytes and the live state of five general-purpose input pins.

Top module: `hub_nibble_target`

## Requirements
- R1: A frame opens only when `frame_n` is low and `bus_in` carries 4'b1101 (read) or 4'b1110 (write) at a clock edge. Any other value on such an edge leaves the target idle: it does not drive the bus and raises no request.
- R2: The clock after the opening code carries the select nibble. If it differs from `id_strap`, the target neither drives the bus nor raises a request for the rest of that frame.
- R3: The seven clocks after the select nibble carry the address, most significant nibble first, so address bits [27:24] arrive first and bits [3:0] last. For a memory access, `req_addr` equals the assembled 28-bit value. One size clock follows the address; its value is not checked.
- R4: In a read, the host owns the bus for the two turnaround clocks after the size clock. The target then drives the handshake nibble, then the data low nibble (bits [3:0]), then the high nibble (bits [7:4]). Next it drives 4'b1111 for one clock, and on the clock after that it releases the bus.
- R5: While the internal port has not answered, every handshake clock carries a wait code. The first SHORT_WAITS of these (default 4) carry 4'b0101; all later ones carry 4'b0110. Once the answer has been captured, the handshake carries 4'b0000. A port that answers within one clock of the request gives no wait clocks; an answer after L clocks (L ≥ 1) gives L−1 wait clocks.
- R6: An answer with `rsp_err` high makes the handshake carry 4'b1010 instead of 4'b0000. A read still goes on through its two data clocks, carrying the returned byte.
- R7: In a write, the host sends the data low nibble first, then the high nibble, right after the size clock. These are followed by two host-owned turnaround clocks. The target then drives the handshake, then 4'b1111 for one clock, then releases the bus. `req_write` is 1 and `req_wdata` holds the received byte.
- R8: With address bit 22 at 0, no request is raised and the handshake reads 4'b0000 at once. Read offsets (address bits [15:0]) return these values: 0x0000 gives MFR_ID, 0x0001 gives DEV_ID, 0x0100 gives {3'b000, gpi}, and any other offset gives 0x00. Writes to this window change nothing.
- R9: A low `frame_n` carrying a valid opening code at any point in a frame discards the frame in progress and starts decoding a new one.
- R10: `rst` is synchronous and active high. From the clock after it is sampled high, the bus is released and no request is pending.
- R11: `bus_oe` is high only in the clocks the target owns (handshake, read data, final 4'b1111). Once raised, `req_valid` stays high with a steady address and direction until `rsp_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Frame strobe, active low |
| bus_in | input | 4 | Value seen on the shared nibble bus |
| bus_out | output | 4 | Nibble driven by the target |
| bus_oe | output | 1 | Target drive enable for the nibble bus |
| id_strap | input | 4 | Select value this target answers to |
| gpi | input | 5 | General-purpose input pins read through the register window |
| req_valid | output | 1 | Internal request pending |
| req_write | output | 1 | Request direction, 1 = write |
| req_addr | output | 28 | Request address |
| req_wdata | output | 8 | Write byte |
| rsp_ready | input | 1 | Internal port answers in this cycle |
| rsp_err | input | 1 | Answer is an error |
| rsp_rdata | input | 8 | Read byte returned with the answer |

## Verification
The tightest coincidence is the internal answer landing on the same clock edge that moves the frame from turnaround into the handshake. The handshake must then show ready, or error, in its very first clock, with no wait code in between. The bench provokes this with reads answered after one clock, once with the error flag set. It judges the outcome by the count and value of the handshake nibbles and by the data that follows. A second coincidence is a new opening code arriving while an address is half received. It is judged by whether the later frame completes with the correct address at the request port.

// File: rtl/hub_pkg.sv
package hub_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_IDSEL, PH_ADDR, PH_MSIZE, PH_WD0, PH_WD1,
    PH_TAR1, PH_TAR2, PH_SYNC, PH_RD0, PH_RD1, PH_TAR3
  } hub_phase_t;

  localparam logic [3:0] CODE_RD      = 4'b1101;
  localparam logic [3:0] CODE_WR      = 4'b1110;
  localparam logic [3:0] SYNC_READY   = 4'b0000;
  localparam logic [3:0] SYNC_SHORT   = 4'b0101;
  localparam logic [3:0] SYNC_LONG    = 4'b0110;
  localparam logic [3:0] SYNC_ERROR   = 4'b1010;
  localparam logic [3:0] NIB_RELEASE  = 4'b1111;
endpackage

// File: rtl/hub_reg_window.sv
module hub_reg_window #(
  parameter int          OFS_W   = 16,
  parameter int          GPI_W   = 5,
  parameter logic [7:0]  MFR_ID  = 8'hC3,
  parameter logic [7:0]  DEV_ID  = 8'h5E,
  parameter logic [15:0] GPI_OFS = 16'h0100
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [GPI_W-1:0] gpi,
  output logic [7:0]       rdata
);
  localparam int PAD_W = 8 - GPI_W;

  always_comb begin
    if (offset == OFS_W'(0))            rdata = MFR_ID;
    else if (offset == OFS_W'(1))       rdata = DEV_ID;
    else if (offset == OFS_W'(GPI_OFS)) rdata = {{PAD_W{1'b0}}, gpi};
    else                                rdata = 8'h00;
  end
endmodule

// File: rtl/hub_frame_fsm.sv
module hub_frame_fsm
  import hub_pkg::*;
#(
  parameter int ADDR_W      = 28,
  parameter int SEL_BIT     = 22,
  parameter int SHORT_WAITS = 4,
  localparam int ADDR_NIBS  = ADDR_W / 4,
  localparam int NIB_CNT_W  = $clog2(ADDR_NIBS),
  localparam int WAIT_W     = $clog2(SHORT_WAITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [3:0]        bus_in,
  input  logic [3:0]        id_strap,
  input  logic              rsp_ready,
  input  logic              rsp_err,
  input  logic [7:0]        rsp_rdata,
  input  logic [7:0]        reg_rdata,
  output hub_phase_t        phase,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        dbuf,
  output logic              done,
  output logic              err,
  output logic [WAIT_W-1:0] wcnt,
  output logic              req_valid
);
  logic [NIB_CNT_W-1:0] nib_cnt;
  logic                 reg_space;
  logic                 open_code;

  assign reg_space = ~addr[SEL_BIT];
  assign open_code = (bus_in == CODE_RD) || (bus_in == CODE_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      is_write  <= 1'b0;
      req_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      wcnt      <= '0;
      nib_cnt   <= '0;
      addr      <= '0;
      dbuf      <= '0;
    end else if (!frame_n) begin
      req_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      wcnt      <= '0;
      nib_cnt   <= '0;
      if (open_code) begin
        phase    <= PH_IDSEL;
        is_write <= (bus_in == CODE_WR);
      end else begin
        phase    <= PH_IDLE;
      end
    end else begin
      if (req_valid && rsp_ready) begin
        req_valid <= 1'b0;
        done      <= 1'b1;
        err       <= rsp_err;
        if (!is_write) dbuf <= rsp_rdata;
      end
      unique case (phase)
        PH_IDLE:  phase <= PH_IDLE;
        PH_IDSEL: phase <= (bus_in == id_strap) ? PH_ADDR : PH_IDLE;
        PH_ADDR: begin
          addr    <= {addr[ADDR_W-5:0], bus_in};
          nib_cnt <= nib_cnt + 1'b1;
          if (nib_cnt == NIB_CNT_W'(ADDR_NIBS - 1)) phase <= PH_MSIZE;
        end
        PH_MSIZE: begin
          if (is_write) begin
            phase <= PH_WD0;
          end else begin
            phase <= PH_TAR1;
            if (reg_space) begin
              done <= 1'b1;
              dbuf <= reg_rdata;
            end else begin
              req_valid <= 1'b1;
            end
          end
        end
        PH_WD0: begin
          dbuf[3:0] <= bus_in;
          phase     <= PH_WD1;
        end
        PH_WD1: begin
          dbuf[7:4] <= bus_in;
          phase     <= PH_TAR1;
          if (reg_space) done <= 1'b1;
          else           req_valid <= 1'b1;
        end
        PH_TAR1: phase <= PH_TAR2;
        PH_TAR2: phase <= PH_SYNC;
        PH_SYNC: begin
          if (done) phase <= is_write ? PH_TAR3 : PH_RD0;
          else if (wcnt != WAIT_W'(SHORT_WAITS)) wcnt <= wcnt + 1'b1;
        end
        PH_RD0:  phase <= PH_RD1;
        PH_RD1:  phase <= PH_TAR3;
        PH_TAR3: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hub_bus_drive.sv
module hub_bus_drive
  import hub_pkg::*;
#(
  parameter int SHORT_WAITS = 4,
  localparam int WAIT_W     = $clog2(SHORT_WAITS + 1)
) (
  input  hub_phase_t        phase,
  input  logic              done,
  input  logic              err,
  input  logic [WAIT_W-1:0] wcnt,
  input  logic [7:0]        dbuf,
  output logic [3:0]        bus_out,
  output logic              bus_oe
);
  always_comb begin
    bus_oe  = 1'b1;
    bus_out = 4'b0000;
    unique case (phase)
      PH_SYNC: begin
        if (done)                            bus_out = err ? SYNC_ERROR : SYNC_READY;
        else if (wcnt < WAIT_W'(SHORT_WAITS)) bus_out = SYNC_SHORT;
        else                                 bus_out = SYNC_LONG;
      end
      PH_RD0:  bus_out = dbuf[3:0];
      PH_RD1:  bus_out = dbuf[7:4];
      PH_TAR3: bus_out = NIB_RELEASE;
      default: bus_oe  = 1'b0;
    endcase
  end
endmodule

// File: rtl/hub_nibble_target.sv
module hub_nibble_target
  import hub_pkg::*;
#(
  parameter int          ADDR_W      = 28,
  parameter int          SEL_BIT     = 22,
  parameter int          SHORT_WAITS = 4,
  parameter int          OFS_W       = 16,
  parameter int          GPI_W       = 5,
  parameter logic [7:0]  MFR_ID      = 8'hC3,
  parameter logic [7:0]  DEV_ID      = 8'h5E,
  parameter logic [15:0] GPI_OFS     = 16'h0100,
  localparam int WAIT_W = $clog2(SHORT_WAITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [3:0]        bus_in,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  input  logic [3:0]        id_strap,
  input  logic [GPI_W-1:0]  gpi,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_wdata,
  input  logic              rsp_ready,
  input  logic              rsp_err,
  input  logic [7:0]        rsp_rdata
);
  hub_phase_t        phase;
  logic [7:0]        dbuf;
  logic [7:0]        reg_rdata;
  logic              done;
  logic              err;
  logic [WAIT_W-1:0] wcnt;

  hub_frame_fsm #(
    .ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .SHORT_WAITS(SHORT_WAITS)
  ) u_fsm (
    .clk(clk), .rst(rst), .frame_n(frame_n), .bus_in(bus_in),
    .id_strap(id_strap), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .reg_rdata(reg_rdata), .phase(phase),
    .is_write(req_write), .addr(req_addr), .dbuf(dbuf), .done(done),
    .err(err), .wcnt(wcnt), .req_valid(req_valid)
  );

  hub_reg_window #(
    .OFS_W(OFS_W), .GPI_W(GPI_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID),
    .GPI_OFS(GPI_OFS)
  ) u_regs (
    .offset(req_addr[OFS_W-1:0]), .gpi(gpi), .rdata(reg_rdata)
  );

  hub_bus_drive #(.SHORT_WAITS(SHORT_WAITS)) u_drive (
    .phase(phase), .done(done), .err(err), .wcnt(wcnt), .dbuf(dbuf),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  assign req_wdata = dbuf;
endmodule

// File: rtl/hub_nibble_target_chk.sv
module hub_nibble_target_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_n,
  input logic [3:0]        bus_in,
  input logic              bus_oe,
  input logic [3:0]        id_strap,
  input logic              req_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write
);
  logic seen_open;

  always_ff @(posedge clk) begin
    if (rst) seen_open <= 1'b0;
    else     seen_open <= !frame_n && (bus_in == 4'b1101 || bus_in == 4'b1110);
  end

  // R1
  bad_open_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_n && bus_in != 4'b1101 && bus_in != 4'b1110) |=> (!bus_oe && !req_valid));

  // R2
  id_miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_open && frame_n && bus_in != id_strap) |=> (!bus_oe && !req_valid));

  // R10
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_oe && !req_valid));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rsp_ready && frame_n) |=>
      (req_valid && $stable(req_addr) && $stable(req_write)));

  // R11
  host_owns_select_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> !bus_oe);
endmodule

bind hub_nibble_target hub_nibble_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .frame_n(frame_n), .bus_in(bus_in), .bus_oe(bus_oe),
  .id_strap(id_strap), .req_valid(req_valid), .rsp_ready(rsp_ready),
  .req_addr(req_addr), .req_write(req_write)
);

// File: tb/hub_nibble_target_tb.sv
module hub_nibble_target_tb;
  localparam logic [3:0] MY_ID = 4'h3;
  localparam int         SHORT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1;
  logic [3:0] host_nib = 4'hF;
  logic [3:0] bus_in, bus_out;
  logic bus_oe;
  logic [4:0] gpi = 5'b10110;
  logic req_valid, req_write;
  logic [27:0] req_addr;
  logic [7:0] req_wdata;
  logic rsp_ready = 1'b0, rsp_err = 1'b0;
  logic [7:0] rsp_rdata = 8'h00;

  int n_chk = 0, n_err = 0;
  int cfg_lat = 0;
  logic cfg_err = 1'b0;
  logic [7:0] cfg_rdata = 8'h00;

  typedef struct { logic [27:0] a; logic w; logic [7:0] d; } exp_req_t;
  exp_req_t exp_q[$];

  always #2 clk = ~clk;
  assign bus_in = bus_oe ? bus_out : host_nib;

  hub_nibble_target u_dut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .id_strap(MY_ID), .gpi(gpi), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // internal port model
  initial forever begin
    @(negedge clk);
    if (req_valid && !rsp_ready && !rst) begin
      repeat (cfg_lat) @(negedge clk);
      rsp_ready = 1'b1; rsp_err = cfg_err; rsp_rdata = cfg_rdata;
      @(negedge clk);
      rsp_ready = 1'b0; rsp_err = 1'b0;
    end
  end

  // scoreboard monitor
  always @(posedge clk) begin
    if (!rst && req_valid && rsp_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R8 unexpected request actual=%0h expected=none", req_addr);
      end else begin
        exp_req_t e;
        e = exp_q.pop_front();
        if (req_addr !== e.a || req_write !== e.w || (e.w && req_wdata !== e.d)) begin
          n_err++;
          $display("FAIL R3/R7 request actual=%0h/%0b/%0h expected=%0h/%0b/%0h",
                   req_addr, req_write, req_wdata, e.a, e.w, e.d);
        end
      end
    end
  end

  task automatic header(input bit wr, input logic [3:0] id, input logic [27:0] a);
    @(negedge clk); frame_n = 1'b0; host_nib = wr ? 4'hE : 4'hD;
    @(negedge clk); frame_n = 1'b1; host_nib = id;
    for (int i = 6; i >= 0; i--) begin @(negedge clk); host_nib = a[i*4 +: 4]; end
    @(negedge clk); host_nib = 4'h0;
  endtask

  task automatic host_tar(input string tag);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); chk({tag, " R11 host turnaround oe"}, 32'(bus_oe), 0); host_nib = 4'hF;
    end
  endtask

  task automatic sync_phase(input string tag, input int exp_waits, input logic [3:0] fin);
    int waits = 0;
    bit stop = 0;
    logic [3:0] code = 4'h0;
    while (!stop) begin
      @(negedge clk);
      code = bus_out;
      if (!bus_oe) begin chk({tag, " R4 sync oe"}, 0, 1); stop = 1; end
      else if (code == 4'h0 || code == 4'hA || waits > 64) stop = 1;
      else begin
        chk({tag, " R5 wait code"}, 32'(code), (waits < SHORT) ? 5 : 6);
        waits++;
      end
    end
    chk({tag, " R5 wait count"}, 32'(waits), 32'(exp_waits));
    chk({tag, " R6 final sync"}, 32'(code), 32'(fin));
  endtask

  task automatic read_frame(input string tag, input logic [27:0] a, input bit mem,
                            input int lat, input logic e, input logic [7:0] d,
                            input logic [3:0] fin);
    cfg_lat = lat; cfg_err = e; cfg_rdata = d;
    if (mem) exp_q.push_back('{a, 1'b0, 8'h00});
    header(1'b0, MY_ID, a);
    host_tar(tag);
    sync_phase(tag, (mem && lat > 0) ? lat - 1 : 0, fin);
    @(negedge clk); chk({tag, " R4 data low"},  32'({bus_oe, bus_out}), 32'({1'b1, d[3:0]}));
    @(negedge clk); chk({tag, " R4 data high"}, 32'({bus_oe, bus_out}), 32'({1'b1, d[7:4]}));
    @(negedge clk); chk({tag, " R4 final tar"}, 32'({bus_oe, bus_out}), 32'h1F);
    @(negedge clk); chk({tag, " R4 release"},   32'(bus_oe), 0);
  endtask

  task automatic write_frame(input string tag, input logic [27:0] a, input bit mem,
                             input int lat, input logic [7:0] d);
    cfg_lat = lat; cfg_err = 1'b0;
    if (mem) exp_q.push_back('{a, 1'b1, d});
    header(1'b1, MY_ID, a);
    @(negedge clk); host_nib = d[3:0];
    @(negedge clk); host_nib = d[7:4];
    host_tar(tag);
    sync_phase(tag, (mem && lat > 0) ? lat - 1 : 0, 4'h0);
    @(negedge clk); chk({tag, " R7 final tar"}, 32'({bus_oe, bus_out}), 32'h1F);
    @(negedge clk); chk({tag, " R7 release"},   32'(bus_oe), 0);
  endtask

  task automatic quiet_window(input string tag, input int n);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); host_nib = 4'hF;
      if (bus_oe || req_valid) hits++;
    end
    chk(tag, 32'(hits), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset oe", 32'(bus_oe), 0);
    chk("R10 reset req", 32'(req_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    read_frame("R4 read fast", 28'h0E5A3C1, 1, 0, 1'b0, 8'h6B, 4'h0);
    read_frame("R5 read slow", 28'h0E00010, 1, 8, 1'b0, 8'hD2, 4'h0);
    read_frame("R6 read err edge", 28'h0F12345, 1, 1, 1'b1, 8'h3C, 4'hA);
    write_frame("R7 write", 28'h07F0010, 1, 2, 8'h96);
    write_frame("R7 write fast", 28'h07F0011, 1, 0, 8'hF1);

    read_frame("R8 mfr id", 28'hFBC0000, 0, 0, 1'b0, 8'hC3, 4'h0);
    read_frame("R8 dev id", 28'hFBC0001, 0, 0, 1'b0, 8'h5E, 4'h0);
    read_frame("R8 gpi", 28'hFBC0100, 0, 0, 1'b0, 8'h16, 4'h0);
    gpi = 5'b01001;
    read_frame("R8 gpi live", 28'hFBC0100, 0, 0, 1'b0, 8'h09, 4'h0);
    read_frame("R8 empty ofs", 28'hFBC0042, 0, 0, 1'b0, 8'h00, 4'h0);
    write_frame("R8 reg write", 28'hFBC0001, 0, 0, 8'h00);
    read_frame("R8 dev id kept", 28'hFBC0001, 0, 0, 1'b0, 8'h5E, 4'h0);

    // R1: invalid opening code
    @(negedge clk); frame_n = 1'b0; host_nib = 4'hC;
    @(negedge clk); frame_n = 1'b1; host_nib = MY_ID;
    for (int i = 6; i >= 0; i--) begin @(negedge clk); host_nib = 4'h4; end
    quiet_window("R1 bad open quiet", 16);

    // R2: select mismatch
    header(1'b0, 4'h9, 28'h0E5A3C1);
    quiet_window("R2 id mismatch quiet", 16);

    // R9: restart in the middle of an address
    @(negedge clk); frame_n = 1'b0; host_nib = 4'hE;
    @(negedge clk); frame_n = 1'b1; host_nib = MY_ID;
    for (int i = 0; i < 3; i++) begin @(negedge clk); host_nib = 4'h7; end
    read_frame("R9 restart", 28'h0C0FFEE, 1, 1, 1'b0, 8'hA5, 4'h0);

    // R10: reset in the middle of a wait
    cfg_lat = 20; cfg_err = 1'b0;
    header(1'b0, MY_ID, 28'h0E00020);
    host_tar("R10 pre");
    repeat (3) @(negedge clk);
    chk("R10 waiting oe", 32'(bus_oe), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid reset oe", 32'(bus_oe), 0);
    chk("R10 mid reset req", 32'(req_valid), 0);
    rst = 1'b0;
    repeat (24) @(negedge clk);
    read_frame("R10 recover", 28'h0E00030, 1, 0, 1'b0, 8'h44, 4'h0);

    repeat (4) @(negedge clk);
    chk("R3 scoreboard drained", 32'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule